// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block watches the command pins of a four-bank DDR SDRAM on every rising clock edge and runs one state machine per bank. It decodes chip select, row strobe, column strobe, write enable, the bank address and address bit 10. Each bank moves through idle, activating, active, read, read with auto-precharge, write, write recovery, write with auto-precharge, precharging and refresh. The dwell times come from counters loaded from the tRCD, tRP, tWR and tRC parameters and from the burst length. Data transfers on both clock edges, so a burst occupies half as many clock cycles as it has beats.

Each command is checked against the state of the bank it addresses. Commands that address all banks are checked against every bank. An illegal command is ignored: it changes no bank and reloads no timer. It raises a one-cycle flag, and a field names the offending bank. Banks that a command does not address keep running on their own timers. They can accept their own commands while a neighbour is locked in a write with auto-precharge. The encoded state of every bank is brought out for monitors and test benches.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank reports idle (state code 0) and the illegal flag is low.
- R2: Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: 1xxx deselect, 0111 no-op, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge, 0001 auto-refresh, 0000 mode-register set. Deselect and no-op are always legal and change no bank state, whatever the levels of the other pins.
- R3: Activate is legal only for an idle bank. The bank then reports activating (code 1) for T_RCD cycles, starting the cycle after the command, and then active (code 2).
- R4: Read is legal only in active or read. With a10 low the bank reports read (code 3) for BURST_LEN/2 cycles and then active. With a10 high it reports read with auto-precharge (code 4) for BURST_LEN/2 cycles and then precharging.
- R5: A plain write (a10 low) is legal in active, write or write recovery. The bank reports write (code 5) for BURST_LEN/2 cycles, then write recovery (code 7) for T_WR cycles, then active.
- R6: A write with a10 high puts the bank in write with auto-precharge (code 6) for BURST_LEN/2+T_WR cycles, then in precharging. While in code 6, every command that addresses that bank is illegal, except deselect and no-op. Other banks still accept their own commands.
- R7: A single precharge (a10 low) is legal in idle, precharging, active and read. From active or read it starts precharging (code 8) for T_RP cycles, after which the bank is idle. Precharge with a10 high addresses all banks and is legal only if it is legal for each one.
- R8: Burst stop addresses the bank given by ba. It is legal in active and read, and a bank in read reports active the next cycle.
- R9: A write while any bank is in read or read with auto-precharge is illegal. After a burst stop has ended the read, the same write is legal.
- R10: Auto-refresh and mode-register set are legal only when every bank is idle. Auto-refresh puts all banks in refresh (code 9) for T_RC cycles, then back to idle. Mode-register set changes no state.
- R11: An illegal command raises illegal for one cycle, the cycle after the command. illegal_bank gives the addressed bank, or the lowest-numbered offending bank for all-bank commands. No bank state or timer is changed by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| illegal_bank | output | BANK_W | Offending bank when illegal is high, else 0 |
| bank_state | output | 4*2^BANK_W | State code of bank i in bits [4i+3:4i] |

## Verification
The bench builds the tracker with T_RCD=3, T_RP=2, T_WR=5, T_RC=6 and an eight-beat burst (four clock cycles per burst). All dwell windows therefore differ from one another. A timer loaded with the wrong constant, or an off-by-one in a counter, moves a state edge to a cycle the bench samples. The long write-with-auto-precharge window (nine cycles) leaves room to aim every rejected command kind at the locked bank. In the same window, the bench activates a second bank and issues an all-bank command whose lowest offender must be reported.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

    typedef enum logic [3:0] {
        OP_DESL  = 4'd0,
        OP_NOP   = 4'd1,
        OP_BST   = 4'd2,
        OP_READ  = 4'd3,
        OP_WRITE = 4'd4,
        OP_ACT   = 4'd5,
        OP_PRE   = 4'd6,
        OP_REF   = 4'd7,
        OP_MRS   = 4'd8
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ap;      // auto-precharge form of read/write
        logic all_bk;  // command addresses every bank
    } cmd_t;

    typedef enum logic [3:0] {
        BK_IDLE    = 4'd0,
        BK_ACTV    = 4'd1,
        BK_OPEN    = 4'd2,
        BK_RD      = 4'd3,
        BK_RD_AP   = 4'd4,
        BK_WR      = 4'd5,
        BK_WR_AP   = 4'd6,
        BK_WR_REC  = 4'd7,
        BK_PRECH   = 4'd8,
        BK_REFR    = 4'd9
    } bank_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_t cmd_o
);

    always_comb begin
        cmd_o = '{op: OP_DESL, ap: 1'b0, all_bk: 1'b0};
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o.op = OP_NOP;
                3'b110:  cmd_o.op = OP_BST;
                3'b101:  cmd_o.op = OP_READ;
                3'b100:  cmd_o.op = OP_WRITE;
                3'b011:  cmd_o.op = OP_ACT;
                3'b010:  cmd_o.op = OP_PRE;
                3'b001:  cmd_o.op = OP_REF;
                default: cmd_o.op = OP_MRS;
            endcase
        end
        cmd_o.ap     = a10 && (cmd_o.op == OP_READ || cmd_o.op == OP_WRITE);
        cmd_o.all_bk = (a10 && cmd_o.op == OP_PRE) || cmd_o.op == OP_REF
                       || cmd_o.op == OP_MRS;
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_trk_pkg::*;
#(
    parameter int T_RP      = 3,
    parameter int T_RC      = 10,
    parameter int T_RCD     = 3,
    parameter int T_WR      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_t     cmd_i,
    input  logic     hit_i,
    input  logic     any_read_i,
    input  logic     commit_i,
    output logic     ok_o,
    output bank_st_e state_o
);

    localparam int BEATS = BURST_LEN / 2;
    localparam int MAX_T = imax(imax(T_RP, T_RC), imax(T_RCD, BEATS + T_WR));
    localparam int CNT_W = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RC   = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(T_WR - 1);
    localparam logic [CNT_W-1:0] LD_BST  = CNT_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] LD_WRAP = CNT_W'(BEATS + T_WR - 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bk_reg_t;

    bk_reg_t r_d, r_q;
    logic    timed;

    assign state_o = r_q.st;

    // legality of the current command for this bank
    always_comb begin
        case (cmd_i.op)
            OP_BST, OP_READ:
                ok_o = !hit_i || r_q.st == BK_OPEN || r_q.st == BK_RD;
            OP_WRITE:
                ok_o = !hit_i || ((r_q.st == BK_OPEN || r_q.st == BK_WR
                                   || r_q.st == BK_WR_REC) && !any_read_i);
            OP_ACT:
                ok_o = !hit_i || r_q.st == BK_IDLE;
            OP_PRE:
                ok_o = !hit_i || r_q.st == BK_IDLE || r_q.st == BK_PRECH
                       || r_q.st == BK_OPEN || r_q.st == BK_RD;
            OP_REF, OP_MRS:
                ok_o = r_q.st == BK_IDLE;
            default:
                ok_o = 1'b1;
        endcase
    end

    always_comb begin
        r_d   = r_q;
        timed = r_q.st != BK_IDLE && r_q.st != BK_OPEN;

        if (timed) begin
            if (r_q.cnt == '0) begin
                case (r_q.st)
                    BK_WR:              begin r_d.st = BK_WR_REC; r_d.cnt = LD_WR; end
                    BK_RD_AP, BK_WR_AP: begin r_d.st = BK_PRECH;  r_d.cnt = LD_RP; end
                    BK_PRECH, BK_REFR:  r_d.st = BK_IDLE;
                    default:            r_d.st = BK_OPEN;
                endcase
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end

        if (commit_i && hit_i) begin
            case (cmd_i.op)
                OP_BST: begin
                    if (r_q.st == BK_RD) r_d.st = BK_OPEN;
                end
                OP_READ: begin
                    r_d.st  = cmd_i.ap ? BK_RD_AP : BK_RD;
                    r_d.cnt = LD_BST;
                end
                OP_WRITE: begin
                    r_d.st  = cmd_i.ap ? BK_WR_AP : BK_WR;
                    r_d.cnt = cmd_i.ap ? LD_WRAP : LD_BST;
                end
                OP_ACT: begin
                    r_d.st  = BK_ACTV;
                    r_d.cnt = LD_RCD;
                end
                OP_PRE: begin
                    if (r_q.st == BK_OPEN || r_q.st == BK_RD) begin
                        r_d.st  = BK_PRECH;
                        r_d.cnt = LD_RP;
                    end
                end
                OP_REF: begin
                    r_d.st  = BK_REFR;
                    r_d.cnt = LD_RC;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= BK_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/ddr_illegal_report.sv
module ddr_illegal_report #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BANKS-1:0] ok_i,
    output logic              illegal_o,
    output logic [BANK_W-1:0] bank_o
);

    typedef struct packed {
        logic              ill;
        logic [BANK_W-1:0] bk;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d.ill = !(&ok_i);
        rep_d.bk  = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (!ok_i[i]) rep_d.bk = BANK_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign illegal_o = rep_q.ill;
    assign bank_o    = rep_q.bk;

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_trk_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int T_RP      = 3,
    parameter int T_RC      = 10,
    parameter int T_RCD     = 3,
    parameter int T_WR      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           ba,
    input  logic                        a10,
    output logic                        illegal,
    output logic [BANK_W-1:0]           illegal_bank,
    output logic [(1<<BANK_W)*4-1:0]    bank_state
);

    localparam int NUM_BANKS = 1 << BANK_W;

    cmd_t                 cmd;
    logic [NUM_BANKS-1:0] ok_vec;
    logic [NUM_BANKS-1:0] rd_vec;
    logic                 any_read;
    logic                 commit;
    bank_st_e             st [NUM_BANKS];

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd_o (cmd)
    );

    assign any_read = |rd_vec;
    assign commit   = (&ok_vec) && cmd.op != OP_DESL && cmd.op != OP_NOP;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit       = cmd.all_bk || (ba == BANK_W'(g));
        assign rd_vec[g] = st[g] == BK_RD || st[g] == BK_RD_AP;
        assign bank_state[g*4 +: 4] = st[g];

        ddr_bank_fsm #(
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .T_RCD     (T_RCD),
            .T_WR      (T_WR),
            .BURST_LEN (BURST_LEN)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_i      (cmd),
            .hit_i      (hit),
            .any_read_i (any_read),
            .commit_i   (commit),
            .ok_o       (ok_vec[g]),
            .state_o    (st[g])
        );
    end

    ddr_illegal_report #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .ok_i      (ok_vec),
        .illegal_o (illegal),
        .bank_o    (illegal_bank)
    );

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
    parameter int BANK_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     ras_n,
    input logic                     cas_n,
    input logic                     we_n,
    input logic [BANK_W-1:0]        ba,
    input logic                     a10,
    input logic                     illegal,
    input logic [BANK_W-1:0]        illegal_bank,
    input logic [(1<<BANK_W)*4-1:0] bank_state
);

    localparam int NB = 1 << BANK_W;

    logic quiet, is_act, is_wr, is_pre, is_glob;
    logic reading, all_idle;

    assign quiet   = cs_n || (ras_n && cas_n && we_n);
    assign is_act  = !cs_n && !ras_n && cas_n && we_n;
    assign is_wr   = !cs_n && ras_n && !cas_n && !we_n;
    assign is_pre  = !cs_n && !ras_n && cas_n && !we_n;
    assign is_glob = !cs_n && !ras_n && !cas_n;

    always_comb begin
        reading  = 1'b0;
        all_idle = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (bank_state[i*4 +: 4] == 4'd3 || bank_state[i*4 +: 4] == 4'd4)
                reading = 1'b1;
            if (bank_state[i*4 +: 4] != 4'd0) all_idle = 1'b0;
        end
    end

    p_quiet_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !illegal);

    p_write_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && reading) |=> illegal);

    p_global_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_glob && !all_idle) |=> illegal);

    p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(!quiet));

    for (genvar g = 0; g < NB; g++) begin : g_bk
        logic [3:0] st_g;
        logic       aimed;
        assign st_g  = bank_state[g*4 +: 4];
        assign aimed = !quiet && (ba == BANK_W'(g) || is_glob || (is_pre && a10));

        p_act_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && ba == BANK_W'(g) && st_g != 4'd0)
            |=> (illegal && illegal_bank == BANK_W'(g)));

        p_act_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && ba == BANK_W'(g) && st_g == 4'd0)
            |=> (st_g == 4'd1 && !illegal));

        p_wap_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_g == 4'd6 && aimed) |=> illegal);
    end

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/ddr_bank_tracker_tb.sv
module ddr_bank_tracker_tb;

    localparam logic [3:0] P_DESL = 4'b1000;
    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_BST  = 4'b0110;
    localparam logic [3:0] P_RD   = 4'b0101;
    localparam logic [3:0] P_WR   = 4'b0100;
    localparam logic [3:0] P_ACT  = 4'b0011;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_MRS  = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       a10 = 1'b0;
    logic       illegal;
    logic [1:0] illegal_bank;
    logic [15:0] bank_state;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int    due;
        logic  ill;
        int    bank;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_bank_tracker #(
        .BANK_W(2), .T_RP(2), .T_RC(6), .T_RCD(3), .T_WR(5), .BURST_LEN(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .illegal(illegal),
        .illegal_bank(illegal_bank), .bank_state(bank_state)
    );

    // monitor: compares the flag outputs against queued expectations
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.ill) begin
                if (!(illegal === 1'b1 && int'(illegal_bank) == e.bank)) begin
                    errors++;
                    $display("FAIL %s: illegal=%0b bank=%0d, expected illegal=1 bank=%0d",
                             e.tag, illegal, illegal_bank, e.bank);
                end
            end else if (illegal !== 1'b0) begin
                errors++;
                $display("FAIL %s: illegal=%0b, expected 0", e.tag, illegal);
            end
        end
    end

    task automatic issue(input logic [3:0] pins, input int bank, input logic a_ten,
                         input logic e_ill, input int e_bank, input string tag);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba  = bank[1:0];
        a10 = a_ten;
        e.due = cyc + 1; e.ill = e_ill; e.bank = e_bank; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(P_NOP, 0, 1'b0, 1'b0, 0, "R2");
    endtask

    task automatic chk(input int bank, input int code, input string tag);
        logic [3:0] got;
        got = bank_state[bank*4 +: 4];
        checks++;
        if (int'(got) != code) begin
            errors++;
            $display("FAIL %s: bank %0d state=%0d, expected %0d", tag, bank, got, code);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 4; b++) chk(b, 0, "R1");
        checks++;
        if (illegal !== 1'b0) begin
            errors++;
            $display("FAIL R1: illegal=%0b, expected 0", illegal);
        end

        // R10: mode set and refresh with all banks idle
        issue(P_MRS, 0, 0, 0, 0, "R10");
        issue(P_REF, 0, 0, 0, 0, "R10");           // M0
        for (int b = 0; b < 4; b++) chk(b, 0, "R10");
        nop(1);                                    // M1
        for (int b = 0; b < 4; b++) chk(b, 9, "R10");
        issue(P_ACT, 0, 0, 1, 0, "R11");           // M2 rejected
        nop(1);                                    // M3
        chk(0, 9, "R11");
        nop(3);                                    // M6
        chk(0, 9, "R10");
        nop(1);                                    // M7
        for (int b = 0; b < 4; b++) chk(b, 0, "R10");

        // R3: activate bank 1
        issue(P_ACT, 1, 0, 0, 0, "R3");            // A0
        nop(1);  chk(1, 1, "R3");                  // A1
        issue(P_ACT, 1, 0, 1, 1, "R3");            // A2 rejected
        nop(1);  chk(1, 1, "R3");                  // A3
        nop(1);  chk(1, 2, "R3");                  // A4

        // R6: write with auto-precharge locks bank 1 only
        issue(P_WR, 1, 1, 0, 0, "R6");             // W0
        nop(1);  chk(1, 6, "R6");                  // W1
        issue(P_ACT, 2, 0, 0, 0, "R6");            // W2 other bank accepted
        issue(P_RD,  1, 0, 1, 1, "R6");            // W3
        issue(P_PRE, 1, 0, 1, 1, "R6");            // W4
        issue(P_ACT, 1, 0, 1, 1, "R6");            // W5
        issue(P_BST, 1, 0, 1, 1, "R6");            // W6
        issue(P_MRS, 0, 0, 1, 1, "R11");           // W7 lowest offender
        issue(P_WR,  1, 0, 1, 1, "R6");            // W8
        nop(1);  chk(1, 6, "R6"); chk(2, 2, "R6"); // W9
        nop(1);  chk(1, 8, "R6");                  // W10
        nop(1);  chk(1, 8, "R7");                  // W11
        nop(1);  chk(1, 0, "R7");                  // W12

        // R8/R9/R5: read, write attempt, burst stop, write
        issue(P_RD, 2, 0, 0, 0, "R4");             // R0
        issue(P_WR, 2, 0, 1, 2, "R9");             // R1 rejected
        nop(1);  chk(2, 3, "R4");                  // R2
        issue(P_BST, 2, 0, 0, 0, "R8");            // R3
        issue(P_WR, 2, 0, 0, 0, "R9");             // R4
        chk(2, 2, "R8");
        nop(1);  chk(2, 5, "R5");                  // R5
        nop(3);  chk(2, 5, "R5");                  // R8
        nop(1);  chk(2, 7, "R5");                  // R9
        nop(4);  chk(2, 7, "R5");                  // R13
        nop(1);  chk(2, 2, "R5");                  // R14

        // R4: plain read length, then read with auto-precharge
        issue(P_RD, 2, 0, 0, 0, "R4");             // X0
        nop(4);  chk(2, 3, "R4");                  // X4
        nop(1);  chk(2, 2, "R4");                  // X5
        issue(P_RD, 2, 1, 0, 0, "R4");             // E0
        nop(1);  chk(2, 4, "R4");                  // E1
        nop(3);  chk(2, 4, "R4");                  // E4
        nop(1);  chk(2, 8, "R7");                  // E5
        nop(1);  chk(2, 8, "R7");                  // E6
        nop(1);  chk(2, 0, "R7");                  // E7

        // R7: precharge all
        issue(P_ACT, 0, 0, 0, 0, "R3");            // P0
        issue(P_PRE, 0, 1, 1, 0, "R7");            // P1 rejected
        nop(2);  chk(0, 1, "R7");                  // P3
        nop(1);  chk(0, 2, "R3");                  // P4
        issue(P_PRE, 3, 1, 0, 0, "R7");            // P5
        nop(1);  chk(0, 8, "R7");                  // P6
        nop(2);  chk(0, 0, "R7");                  // P8
        issue(P_PRE, 3, 0, 0, 0, "R7");            // P9
        nop(1);  chk(3, 0, "R7");                  // P10

        // R2/R10/R4: deselect, global commands with a bank open
        issue(P_ACT, 3, 0, 0, 0, "R3");            // G0
        nop(3);                                    // G3
        issue(P_DESL, 3, 1, 0, 0, "R2");           // G4
        nop(1);  chk(3, 2, "R2");                  // G5
        issue(P_MRS, 0, 0, 1, 3, "R10");           // G6
        issue(P_REF, 0, 0, 1, 3, "R10");           // G7
        issue(P_RD,  0, 0, 1, 0, "R4");            // G8
        issue(P_PRE, 3, 0, 0, 0, "R7");            // G9
        nop(1);  chk(3, 8, "R7");                  // G10
        nop(2);  chk(3, 0, "R7");                  // G12
        nop(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule